// File: doc/BRIEF.md
# Saturating Fractional Adder/Subtractor

This block adds or subtracts two n-bit two's-complement fractions (default n = 8) whose binary point sits directly after the sign bit, so the representable range is -1.0 up to 1 - 2^-(n-1). The sum comes from a carry-lookahead network that is built from 4-bit generate/propagate groups. The result is purely combinational and is valid in the same cycle as the operands.

When the true result does not fit in n bits, the block clamps it. A positive overshoot gives the largest positive code, 0 followed by all ones. A negative overshoot gives the most negative code, 1 followed by all zeros. Overflow is found by comparing the carry that enters the sign bit with the carry that leaves it. The signs of the two effective operands then decide the direction, and each direction has its own flag.

Subtraction inverts the second operand and forces the carry-in to 1. The overflow decision therefore always looks at the operand that actually enters the adder.

Top module: `sat_cla_adder`

## Requirements
- R1: When the signed result of the selected operation lies in [-2^(n-1), 2^(n-1)-1], `sum_o` equals that result as an n-bit two's-complement code and both flags are 0.
- R2: When the signed result exceeds 2^(n-1)-1, `sum_o` is 0 followed by n-1 ones (0x7F at n = 8) and `ovf_pos_o` is 1.
- R3: When the signed result is below -2^(n-1), `sum_o` is 1 followed by n-1 zeros (0x80 at n = 8) and `ovf_neg_o` is 1.
- R4: `ovf_pos_o` and `ovf_neg_o` are never 1 together. `ovf_pos_o` requires both effective operand sign bits to be 0, and `ovf_neg_o` requires both to be 1.
- R5: With `sub_i` = 1 the operation is a − b. It is carried out as a + ~b + 1, with the same saturation and flags as addition. With `sub_i` = 0 the operation is a + b.
- R6: Subtracting the most negative value (1000…0) from a non-negative `a` saturates to the largest positive code and raises `ovf_pos_o`.
- R7: Overflow is the XOR of the carry into the sign bit and the carry out of it. Operands of opposite effective sign never overflow.
- R8: The output depends only on the present inputs. With all inputs 0, `sum_o` is 0 and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand, two's-complement fraction |
| b_i | input | N | Second operand, two's-complement fraction |
| sub_i | input | 1 | 1 selects a − b, 0 selects a + b |
| sum_o | output | N | Saturated result |
| ovf_pos_o | output | 1 | Result was clamped to the largest positive code |
| ovf_neg_o | output | 1 | Result was clamped to the most negative code |

## Verification
The hardest case to reach is subtracting the most negative operand. There, inverting b produces a positive effective operand whose value is one code short until the forced carry-in adds the last unit. Overflow then depends entirely on the carry chain, not on the raw sign bits. The stimulus gets there by sweeping every operand pair at n = 8 in both modes, and it repeats the boundary pairs as named directed cases. Seeded random vectors follow on top of the sweep.

// File: rtl/sat_cla_pkg.sv
package sat_cla_pkg;

    // Selection made by the clamp stage
    typedef enum logic [1:0] {
        SEL_RAW = 2'd0,
        SEL_MAX = 2'd1,
        SEL_MIN = 2'd2
    } clamp_sel_e;

    localparam int unsigned GROUP_W = 4;

endpackage

// File: rtl/cla_group4.sv
module cla_group4 (
    input  logic [3:0] g_i,
    input  logic [3:0] p_i,
    input  logic       c_i,
    output logic [3:0] c_o,
    output logic       gg_o,
    output logic       pg_o
);

    always_comb begin
        c_o[0] = g_i[0] | (p_i[0] & c_i);
        c_o[1] = g_i[1] | (p_i[1] & g_i[0]) | (p_i[1] & p_i[0] & c_i);
        c_o[2] = g_i[2] | (p_i[2] & g_i[1]) | (p_i[2] & p_i[1] & g_i[0])
               | (p_i[2] & p_i[1] & p_i[0] & c_i);
        c_o[3] = g_i[3] | (p_i[3] & g_i[2]) | (p_i[3] & p_i[2] & g_i[1])
               | (p_i[3] & p_i[2] & p_i[1] & g_i[0])
               | (p_i[3] & p_i[2] & p_i[1] & p_i[0] & c_i);
        gg_o   = g_i[3] | (p_i[3] & g_i[2]) | (p_i[3] & p_i[2] & g_i[1])
               | (p_i[3] & p_i[2] & p_i[1] & g_i[0]);
        pg_o   = &p_i;
    end

    // R7
    always_comb begin
        group_carry_chk: assert ((gg_o | (pg_o & c_i)) == c_o[3])
            else $error("group carry disagrees with bit carry");
    end

endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] x_i,
    input  logic [N-1:0] y_i,
    input  logic         ci_i,
    output logic [N-1:0] s_o,
    output logic         c_sign_in_o,
    output logic         c_sign_out_o
);
    import sat_cla_pkg::*;

    localparam int unsigned NG = (N + GROUP_W - 1) / GROUP_W;
    localparam int unsigned W  = NG * GROUP_W;

    logic [W-1:0]  xp, yp, g, p, cbit, cin_bit, sfull;
    logic [NG-1:0] gg, pg;
    logic [NG-1:0] gcarry;

    assign xp = W'(x_i);
    assign yp = W'(y_i);
    assign g  = xp & yp;
    assign p  = xp ^ yp;

    // group-level lookahead: carry into each group
    always_comb begin
        gcarry[0] = ci_i;
        for (int k = 1; k < NG; k++) begin
            gcarry[k] = gg[k-1] | (pg[k-1] & gcarry[k-1]);
        end
    end

    for (genvar k = 0; k < NG; k++) begin : g_grp
        cla_group4 u_grp (
            .g_i  (g[k*GROUP_W +: GROUP_W]),
            .p_i  (p[k*GROUP_W +: GROUP_W]),
            .c_i  (gcarry[k]),
            .c_o  (cbit[k*GROUP_W +: GROUP_W]),
            .gg_o (gg[k]),
            .pg_o (pg[k])
        );
    end

    assign cin_bit = {cbit[W-2:0], ci_i};
    assign sfull   = p ^ cin_bit;

    assign s_o          = sfull[N-1:0];
    assign c_sign_in_o  = cin_bit[N-1];
    assign c_sign_out_o = cbit[N-1];

    // R1
    always_comb begin
        sum_value_chk: assert ({c_sign_out_o, s_o} ==
                               ({1'b0, x_i} + {1'b0, y_i} + {{N{1'b0}}, ci_i}))
            else $error("lookahead sum disagrees with arithmetic sum");
    end

    // R7
    always_comb begin
        top_group_chk: assert ((gg[NG-1] | (pg[NG-1] & gcarry[NG-1])) ==
                               (({1'b0, xp} + {1'b0, yp} + {{W{1'b0}}, ci_i}) >> W))
            else $error("top group carry wrong");
    end

endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] raw_i,
    input  logic         sa_i,
    input  logic         sb_i,
    input  logic         c_sign_in_i,
    input  logic         c_sign_out_i,
    output logic [N-1:0] res_o,
    output logic         pos_o,
    output logic         neg_o
);
    import sat_cla_pkg::*;

    localparam logic [N-1:0] MAX_POS = {1'b0, {(N-1){1'b1}}};
    localparam logic [N-1:0] MAX_NEG = {1'b1, {(N-1){1'b0}}};

    typedef struct packed {
        clamp_sel_e   sel;
        logic [N-1:0] value;
        logic         pos;
        logic         neg;
    } clamp_t;

    clamp_t res_d;
    logic   ovf;

    always_comb begin
        ovf       = c_sign_in_i ^ c_sign_out_i;
        res_d     = '0;
        res_d.pos = ovf & ~sa_i & ~sb_i;
        res_d.neg = ovf & sa_i & sb_i;
        if (res_d.pos)      res_d.sel = SEL_MAX;
        else if (res_d.neg) res_d.sel = SEL_MIN;
        else                res_d.sel = SEL_RAW;
        case (res_d.sel)
            SEL_MAX: res_d.value = MAX_POS;
            SEL_MIN: res_d.value = MAX_NEG;
            default: res_d.value = raw_i;
        endcase
    end

    assign res_o = res_d.value;
    assign pos_o = res_d.pos;
    assign neg_o = res_d.neg;

    // R4
    always_comb begin
        flags_exclusive_chk: assert ($onehot0({pos_o, neg_o}))
            else $error("both overflow flags set");
    end

    // R2
    always_comb begin
        pos_clamp_chk: assert (!pos_o || res_o == MAX_POS)
            else $error("positive clamp value wrong");
    end

    // R3
    always_comb begin
        neg_clamp_chk: assert (!neg_o || res_o == MAX_NEG)
            else $error("negative clamp value wrong");
    end

    // R1
    always_comb begin
        no_overflow_chk: assert (pos_o || neg_o || res_o == raw_i)
            else $error("unclamped result altered");
    end

    // R7
    always_comb begin
        mixed_sign_chk: assert ((sa_i == sb_i) || !(pos_o || neg_o))
            else $error("overflow with mixed signs");
    end

endmodule

// File: rtl/sat_cla_adder.sv
module sat_cla_adder #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         sub_i,
    output logic [N-1:0] sum_o,
    output logic         ovf_pos_o,
    output logic         ovf_neg_o
);

    logic [N-1:0] b_eff;
    logic [N-1:0] raw_sum;
    logic         c_in_sign, c_out_sign;

    assign b_eff = b_i ^ {N{sub_i}};

    cla_adder #(.N(N)) u_add (
        .x_i          (a_i),
        .y_i          (b_eff),
        .ci_i         (sub_i),
        .s_o          (raw_sum),
        .c_sign_in_o  (c_in_sign),
        .c_sign_out_o (c_out_sign)
    );

    sat_clamp #(.N(N)) u_clamp (
        .raw_i        (raw_sum),
        .sa_i         (a_i[N-1]),
        .sb_i         (b_eff[N-1]),
        .c_sign_in_i  (c_in_sign),
        .c_sign_out_i (c_out_sign),
        .res_o        (sum_o),
        .pos_o        (ovf_pos_o),
        .neg_o        (ovf_neg_o)
    );

    // R6
    always_comb begin
        sub_min_chk: assert (!(sub_i && !a_i[N-1] && b_i == {1'b1, {(N-1){1'b0}}})
                             || ovf_pos_o)
            else $error("subtracting most negative value did not saturate");
    end

    // R5
    always_comb begin
        sub_sign_chk: assert (!ovf_neg_o || (a_i[N-1] && (b_i[N-1] != sub_i)))
            else $error("negative overflow with wrong effective signs");
    end

endmodule

// File: tb/sat_cla_adder_bench.sv
module sat_cla_adder_bench;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] a, b;
    logic         sub;
    logic [N-1:0] sum;
    logic         fpos, fneg;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;

    sat_cla_adder #(.N(N)) u_sat_cla_adder (
        .a_i       (a),
        .b_i       (b),
        .sub_i     (sub),
        .sum_o     (sum),
        .ovf_pos_o (fpos),
        .ovf_neg_o (fneg)
    );

    function automatic void model(input logic [N-1:0] x, input logic [N-1:0] y,
                                  input logic s, output logic [N-1:0] r,
                                  output logic p, output logic n);
        int xv, yv, t;
        xv = int'($signed(x));
        yv = int'($signed(y));
        t  = s ? (xv - yv) : (xv + yv);
        p  = 1'b0;
        n  = 1'b0;
        if (t > (2 ** (N - 1)) - 1) begin
            r = {1'b0, {(N-1){1'b1}}};
            p = 1'b1;
        end else if (t < -(2 ** (N - 1))) begin
            r = {1'b1, {(N-1){1'b0}}};
            n = 1'b1;
        end else begin
            r = t[N-1:0];
        end
    endfunction

    task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y,
                         input logic s, input string tag);
        logic [N-1:0] er;
        logic         ep, en;
        a   = x;
        b   = y;
        sub = s;
        #1;
        model(x, y, s, er, ep, en);
        checks++;
        if (sum !== er || fpos !== ep || fneg !== en) begin
            failures++;
            $display("FAIL %s a=%h b=%h sub=%b actual sum=%h pos=%b neg=%b expected sum=%h pos=%b neg=%b",
                     tag, x, y, s, sum, fpos, fneg, er, ep, en);
        end
        #1;
    endtask

    function automatic string tag_of(input logic [N-1:0] x, input logic [N-1:0] y,
                                     input logic s);
        logic [N-1:0] r;
        logic         p, n;
        model(x, y, s, r, p, n);
        if (p)      return s ? "R5/R2" : "R2";
        else if (n) return s ? "R5/R3" : "R3";
        else        return s ? "R5/R1" : "R1";
    endfunction

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        rst_n = 1'b0;
        a = '0;
        b = '0;
        sub = 1'b0;
        #3;
        // R8: all-zero inputs give zero output and no flags
        checks++;
        if (sum !== '0 || fpos !== 1'b0 || fneg !== 1'b0) begin
            failures++;
            $display("FAIL R8 actual sum=%h pos=%b neg=%b expected sum=00 pos=0 neg=0",
                     sum, fpos, fneg);
        end
        rst_n = 1'b1;

        // directed corners
        apply(8'h40, 8'h40, 1'b0, "R2");
        apply(8'h7F, 8'h01, 1'b0, "R2");
        apply(8'h80, 8'h80, 1'b0, "R3");
        apply(8'h80, 8'hFF, 1'b0, "R3");
        apply(8'h7F, 8'h80, 1'b0, "R7");
        apply(8'h3F, 8'h40, 1'b0, "R1");
        apply(8'h00, 8'h80, 1'b1, "R6");
        apply(8'h7F, 8'h80, 1'b1, "R6");
        apply(8'hFF, 8'h80, 1'b1, "R5");
        apply(8'h80, 8'h01, 1'b1, "R5/R3");
        apply(8'h80, 8'h80, 1'b1, "R4");
        apply(8'h81, 8'h7F, 1'b0, "R4");

        // exhaustive sweep, both modes
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 256; i++) begin
                for (int j = 0; j < 256; j++) begin
                    apply(N'(i), N'(j), m[0], tag_of(N'(i), N'(j), m[0]));
                end
            end
        end

        // seeded random
        seed_dummy = $urandom(32'd20240611);
        for (int k = 0; k < 2000; k++) begin
            logic [N-1:0] rx, ry;
            logic         rs;
            rx = N'($urandom);
            ry = N'($urandom);
            rs = 1'($urandom);
            apply(rx, ry, rs, tag_of(rx, ry, rs));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule